// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-interrupt state of a small peripheral controller. Seven flag bits record events raised by the two timers and the serial shift unit, and seven enable bits choose which of those events may reach the processor. A single level-sensitive interrupt line is driven from the combination of the two registers.

Interrupt sources deliver one-cycle set pulses. Other registers of the controller clear flags as a side effect of being read, and they signal that with one-cycle clear pulses. A byte-wide bus port reads and writes the two registers. A flag write is an acknowledge: every bit written as one is cleared. An enable write uses its top bit to pick the operation. When bit 7 is one, the written ones are added to the enables. When bit 7 is zero, the written ones are removed. A flag read returns a summary in bit 7 that shows whether any pending event is also enabled. An enable read always returns one in bit 7.

Top module: `irq_flag_enable`

## Requirements
- R1: A one on `set_i[k]` at a clock edge sets flag bit k. Bit 2 is shift complete, bit 3 is shift data, bit 4 is shift clock, bit 5 is timer 2 and bit 6 is timer 1. Bits 0 and 1 are general.
- R2: `irq_o` is high exactly when some flag is one with its enable also one, at bit position 2, 5 or 6. Pending enabled events at bits 0, 1, 3 or 4 do not raise `irq_o`.
- R3: A bus write with `reg_sel_i`=0 (flag register) clears each flag bit whose bit in `wdata_i[6:0]` is one. Flags written as zero keep their value.
- R4: A one on `clr_i[k]` at a clock edge clears flag bit k.
- R5: A bus write with `reg_sel_i`=1 (enable register) and `wdata_i[7]`=1 sets each enable bit whose bit in `wdata_i[6:0]` is one. The other enables keep their value.
- R6: A bus write with `reg_sel_i`=1 and `wdata_i[7]`=0 clears each enable bit whose bit in `wdata_i[6:0]` is one. The other enables keep their value.
- R7: With `reg_sel_i`=0, `rdata_o[6:0]` shows the flags. `rdata_o[7]` is one when any of bits 6:0 is set in both the flags and the enables, whatever its position.
- R8: With `reg_sel_i`=1, `rdata_o[6:0]` shows the enables and `rdata_o[7]` is always one.
- R9: After reset the flag register reads 0x00, the enable register reads 0x80 and `irq_o` is low.
- R10: When a set pulse falls in the same cycle as a bus write-clear or a clear pulse on the same bit, the flag ends up set.
- R11: A flag write never sets a flag and leaves the enables unchanged. Without a set pulse, no flag goes from zero to one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_i | input | 7 | One-cycle set pulses, one per flag bit |
| clr_i | input | 7 | One-cycle clear pulses from side-effect reads |
| reg_sel_i | input | 1 | Register select: 0 flag, 1 enable |
| wr_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Several rules are checked by assertions on every cycle. A set pulse always lands in its flag, and it wins over any clear in the same cycle. A write-clear or clear pulse removes the other bits it names. Enable writes add or remove the bits they name. A flag never rises without a set pulse. The enable read always carries its top bit. A raised interrupt line always shows in the flag summary bit. The directed scenarios show the exact values that come back. These cover bits written as zero keeping their value, pending enabled events that do not reach the interrupt line, the summary bit coming from a non-interrupting source, and the reset values.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
    localparam int unsigned N_SRC  = 7;
    localparam int unsigned DATA_W = N_SRC + 1;
    localparam int unsigned TOP_B  = DATA_W - 1;

    // Flag bit positions
    localparam int unsigned B_SHIFT_DONE = 2;
    localparam int unsigned B_SHIFT_DAT  = 3;
    localparam int unsigned B_SHIFT_CLK  = 4;
    localparam int unsigned B_TIMER2     = 5;
    localparam int unsigned B_TIMER1     = 6;

    typedef logic [N_SRC-1:0]  src_vec_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Sources that are allowed to drive the interrupt line
    localparam src_vec_t IRQ_MASK = src_vec_t'((1 << B_SHIFT_DONE) |
                                               (1 << B_TIMER2) |
                                               (1 << B_TIMER1));

    typedef struct packed {
        src_vec_t bits;
    } bank_state_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  src_vec_t wr_clr_i,
    output src_vec_t flags_o
);
    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // clears first, set pulses applied last so they win
        state_d.bits = (state_q.bits & ~(clr_i | wr_clr_i)) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags_o = state_q.bits;
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  byte_t    wdata_i,
    output src_vec_t en_o
);
    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            if (wdata_i[TOP_B]) state_d.bits = state_q.bits | wdata_i[N_SRC-1:0];
            else                state_d.bits = state_q.bits & ~wdata_i[N_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_o = state_q.bits;
endmodule

// File: rtl/irq_readout.sv
module irq_readout
    import irq_fe_pkg::*;
(
    input  src_vec_t flags_i,
    input  src_vec_t en_i,
    input  logic     reg_sel_i,
    output byte_t    rdata_o,
    output logic     irq_o
);
    src_vec_t live;
    logic     irq_bits [N_SRC];

    assign live = flags_i & en_i;

    for (genvar k = 0; k < N_SRC; k++) begin : g_gate
        if (IRQ_MASK[k]) begin : g_on
            assign irq_bits[k] = live[k];
        end else begin : g_off
            assign irq_bits[k] = 1'b0;
        end
    end

    always_comb begin
        irq_o = 1'b0;
        for (int k = 0; k < N_SRC; k++) irq_o = irq_o | irq_bits[k];
    end

    always_comb begin
        if (reg_sel_i) rdata_o = {1'b1, en_i};
        else           rdata_o = {|live, flags_i};
    end
endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable
    import irq_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] set_i,
    input  logic [6:0] clr_i,
    input  logic       reg_sel_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o
);
    src_vec_t flag_vec;
    src_vec_t en_vec;
    src_vec_t wr_clr;
    logic     en_wr;

    assign wr_clr = (wr_i && !reg_sel_i) ? wdata_i[N_SRC-1:0] : '0;
    assign en_wr  = wr_i && reg_sel_i;

    irq_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_i),
        .clr_i    (clr_i),
        .wr_clr_i (wr_clr),
        .flags_o  (flag_vec)
    );

    irq_enable_bank u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (wdata_i),
        .en_o    (en_vec)
    );

    irq_readout u_out (
        .flags_i   (flag_vec),
        .en_i      (en_vec),
        .reg_sel_i (reg_sel_i),
        .rdata_o   (rdata_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/irq_flag_enable_chk.sv
module irq_flag_enable_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] set_i,
    input logic [6:0] clr_i,
    input logic       reg_sel_i,
    input logic       wr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic       irq_o,
    input logic [6:0] flag_vec,
    input logic [6:0] en_vec
);
    // R1 and R10: a set pulse always lands, even against a clear
    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_vec & $past(set_i)) == $past(set_i)));

    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !reg_sel_i) |=> ((flag_vec & $past(wdata_i[6:0] & ~set_i)) == 7'd0));

    a_r4_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((flag_vec & $past(clr_i & ~set_i)) == 7'd0));

    a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && reg_sel_i && wdata_i[7]) |=>
            ((en_vec & $past(wdata_i[6:0])) == $past(wdata_i[6:0])));

    a_r6_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && reg_sel_i && !wdata_i[7]) |=> ((en_vec & $past(wdata_i[6:0])) == 7'd0));

    a_r7_irq_in_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !reg_sel_i) |-> rdata_o[7]);

    a_r8_enable_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel_i |-> rdata_o[7]);

    a_r11_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == 7'd0) |=> ((flag_vec & ~$past(flag_vec)) == 7'd0));
endmodule

bind irq_flag_enable irq_flag_enable_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .reg_sel_i (reg_sel_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .flag_vec  (flag_vec),
    .en_vec    (en_vec)
);

// File: tb/tb_irq_flag_enable.sv
`timescale 1ns/1ps
module tb_irq_flag_enable;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] set_i = '0;
    logic [6:0] clr_i = '0;
    logic       reg_sel_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_flag_enable dut (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
        .reg_sel_i(reg_sel_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel_i = sel; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic pulse_set(input logic [6:0] v);
        @(negedge clk);
        set_i = v;
        @(negedge clk);
        set_i = '0;
    endtask

    task automatic pulse_clr(input logic [6:0] v);
        @(negedge clk);
        clr_i = v;
        @(negedge clk);
        clr_i = '0;
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel_i = sel;
        #1 v = rdata_o;
    endtask

    task automatic wipe();
        bus_write(1'b0, 8'h7F);
        bus_write(1'b1, 8'h7F);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        read_reg(1'b0, v); check("R9 flag reset", v, 8'h00);
        read_reg(1'b1, v); check("R9 enable reset", v, 8'h80);
        check("R9 irq reset", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_timer1_path();
        logic [7:0] v;
        wipe();
        pulse_set(7'h40);
        read_reg(1'b0, v); check("R1 timer1 flag", v, 8'h40);
        check("R2 irq off while disabled", {7'd0, irq_o}, 8'h00);
        bus_write(1'b1, 8'hC0);
        read_reg(1'b1, v); check("R5 enable set", v, 8'hC0);
        check("R2 irq on timer1", {7'd0, irq_o}, 8'h01);
        read_reg(1'b0, v); check("R7 summary set", v, 8'hC0);
    endtask

    task automatic t_other_irq_sources();
        wipe();
        bus_write(1'b1, 8'hA4);
        pulse_set(7'h20);
        check("R2 irq on timer2", {7'd0, irq_o}, 8'h01);
        bus_write(1'b0, 8'h20);
        check("R2 irq drops after ack", {7'd0, irq_o}, 8'h00);
        pulse_set(7'h04);
        check("R2 irq on shift done", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_nonirq_bits();
        logic [7:0] v;
        wipe();
        bus_write(1'b1, 8'h9B);
        pulse_set(7'h1B);
        check("R2 bits 0 1 3 4 no irq", {7'd0, irq_o}, 8'h00);
        read_reg(1'b0, v); check("R7 summary from non-irq bits", v, 8'h9B);
    endtask

    task automatic t_write_clear();
        logic [7:0] v;
        wipe();
        pulse_set(7'h7C);
        bus_write(1'b0, 8'h24);
        read_reg(1'b0, v); check("R3 write clears ones only", v, 8'h58);
        pulse_clr(7'h08);
        read_reg(1'b0, v); check("R4 clear pulse", v, 8'h50);
    endtask

    task automatic t_enable_clear();
        logic [7:0] v;
        wipe();
        read_reg(1'b1, v); check("R6 enable clear all", v, 8'h80);
        bus_write(1'b1, 8'hE4);
        bus_write(1'b1, 8'h24);
        read_reg(1'b1, v); check("R6 enable partial clear", v, 8'hC0);
        bus_write(1'b1, 8'h81);
        read_reg(1'b1, v); check("R5 enable set keeps others", v, 8'hC1);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        wipe();
        @(negedge clk);
        set_i = 7'h10; reg_sel_i = 1'b0; wdata_i = 8'h10; wr_i = 1'b1;
        @(negedge clk);
        set_i = '0; wr_i = 1'b0; wdata_i = '0;
        read_reg(1'b0, v); check("R10 set beats write clear", v, 8'h10);
        @(negedge clk);
        set_i = 7'h02; clr_i = 7'h02;
        @(negedge clk);
        set_i = '0; clr_i = '0;
        read_reg(1'b0, v); check("R10 set beats clear pulse", v, 8'h12);
    endtask

    task automatic t_flag_write_no_set();
        logic [7:0] v;
        wipe();
        bus_write(1'b1, 8'h83);
        bus_write(1'b0, 8'hFF);
        read_reg(1'b0, v); check("R11 flag write sets nothing", v, 8'h00);
        read_reg(1'b1, v); check("R11 enables untouched", v, 8'h83);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timer1_path();
        t_other_irq_sources();
        t_nonirq_bits();
        t_write_clear();
        t_enable_clear();
        t_collision();
        t_flag_write_no_set();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule